// File: doc/BRIEF.md
# Byte-Wide Serial Port Register Block with Interrupt Logic

This block is the host-visible register file of a classic 8-register serial port. It sits between a byte-wide host bus and a byte-stream data path. The host side has a 3-bit offset, a write strobe and a read strobe, each lasting one cycle. The data path has a transmit handshake (`tx_valid`/`tx_ready`) and a receive input with backpressure (`rx_valid`/`rx_ready`). The bit serializer, the baud generator and line-error detection live elsewhere. The block hands them the divisor, the character format and the modem-control bits as configuration outputs.

The block keeps one received byte and one byte waiting to be sent. It raises a level interrupt from a fixed-priority identification code. The transmit-empty interrupt is remembered in a hidden pending flag. Reading the identification register disarms that flag when it reports transmit-empty. Writing the enable register re-arms it while the holding register is empty. A loopback mode makes the modem-status read value show the modem-control outputs.

Top module: `uart16_regs_top`

## Requirements
- R1: Offsets: 0 data, 1 interrupt enable, 2 interrupt identification (read-only, writes ignored), 3 line control, 4 modem control, 5 line status (read-only), 6 modem status (read-only), 7 scratch. The scratch and line-control registers read back the last full byte written.
- R2: While line-control bit 7 is 1, offsets 0 and 1 read and write the low and high bytes of the 16-bit divisor. The divisor goes out on `cfg_divisor`, and the data and enable registers are left untouched.
- R3: A write to the interrupt enable register keeps only bits 3:0. A write to modem control keeps only bits 4:0. The other bits read as 0.
- R4: The identification value is 0x04 when data-ready is set and enable bit 0 is set. Otherwise it is 0x02 when transmit-pending is set and enable bit 1 is set. Otherwise it is 0x01. `irq` is high exactly when the value is not 0x01.
- R5: A read strobe at offset 2 that returns 0x02 clears transmit-pending. If the offset is presented without the strobe, nothing changes.
- R6: A write to the interrupt enable register sets transmit-pending when line-status bit 5 (holding empty) is set.
- R7: A data write with bit 7 clear loads `tx_data` and raises `tx_valid`. It also clears status bits 5 and 6 and transmit-pending. `tx_data` holds until `tx_ready` is seen. The accepting edge sets bits 5 and 6 and transmit-pending.
- R8: `rx_ready` is high only while data-ready (status bit 0) is clear. An accepted byte is stored and sets data-ready. A data read strobe with bit 7 clear clears data-ready. A byte offered while data-ready is set is not taken.
- R9: When modem-control bit 4 is set, modem status reads as follows: control bits 3 and 2 appear at bits 7 and 6, bit 0 at bit 5, and bit 1 at bit 4, with bits 3:0 at zero. Otherwise it reads 0xB0.
- R10: After reset, line status reads 0x60, identification 0x01, modem status 0xB0, and every writable register and the divisor read 0. `irq` and `tx_valid` are low.
- R11: Line control drives the format outputs. `cfg_word_bits` = bits 1:0 plus 5, `cfg_stop2` = bit 2, `cfg_par_en` = bit 3, `cfg_par_even` = bit 4 and `cfg_break` = bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rd | input | 1 | Read strobe, one cycle; side effects on its edge |
| host_rdata | output | 8 | Read data, combinational from the current state |
| irq | output | 1 | Level interrupt request |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Downstream takes the byte |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Block can take a received byte |
| cfg_divisor | output | 16 | Baud divisor |
| cfg_word_bits | output | 4 | Data bits per character (5 to 8) |
| cfg_stop2 | output | 1 | Two stop bits |
| cfg_par_en | output | 1 | Parity enabled |
| cfg_par_even | output | 1 | Even parity selected |
| cfg_break | output | 1 | Force break |
| modem_ctl | output | 5 | Stored modem-control bits (bit 4 loopback) |

## Verification
The hardest situation to reach is the hidden transmit-pending flag colliding with the other events. The stimulus first arms the flag through an enable write. It then parks the identification offset on the bus without a strobe, to show the flag survives. Next it clears the flag with a strobed read and re-arms it with a second enable write. A received byte is then held in place while a transmit byte is stalled by a low `tx_ready`. This makes the receive code take priority over transmit-pending, and the transmit code appears only once the buffer is drained. A behavioural model in the bench tracks every register and is compared with the outputs on every cycle.

// File: rtl/uart16_pkg.sv
package uart16_pkg;

  localparam int BYTE_W   = 8;
  localparam int IEN_BITS = 4;
  localparam int MCTL_BITS = 5;

  typedef enum logic [2:0] {
    OFS_DATA  = 3'd0,
    OFS_IEN   = 3'd1,
    OFS_IID   = 3'd2,
    OFS_LCTL  = 3'd3,
    OFS_MCTL  = 3'd4,
    OFS_LSTAT = 3'd5,
    OFS_MSTAT = 3'd6,
    OFS_SCR   = 3'd7
  } reg_ofs_e;

  localparam logic [BYTE_W-1:0] IID_NONE   = 8'h01;
  localparam logic [BYTE_W-1:0] IID_TXE    = 8'h02;
  localparam logic [BYTE_W-1:0] IID_RXD    = 8'h04;
  localparam logic [BYTE_W-1:0] MSTAT_IDLE = 8'hB0;

  // Fixed-priority identification code
  function automatic logic [BYTE_W-1:0] iid_code(input logic rx_full, input logic rx_en,
                                                  input logic tx_pend, input logic tx_en);
    if (rx_full && rx_en)      return IID_RXD;
    else if (tx_pend && tx_en) return IID_TXE;
    else                       return IID_NONE;
  endfunction

  // Modem-status view while looping back the control outputs
  function automatic logic [BYTE_W-1:0] loop_status(input logic [MCTL_BITS-1:0] mc);
    return {mc[3], mc[2], mc[0], mc[1], 4'b0000};
  endfunction

  function automatic logic [3:0] word_bits(input logic [1:0] sel);
    return {2'b00, sel} + 4'd5;
  endfunction

  function automatic logic [BYTE_W-1:0] line_status(input logic temt, input logic thre,
                                                     input logic rx_full);
    return {1'b0, temt, thre, 4'b0000, rx_full};
  endfunction

endpackage

// File: rtl/uart16_tx_side.sv
module uart16_tx_side #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          thre,
  output logic          temt,
  output logic          accept
);

  assign accept = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      thre     <= 1'b1;
      temt     <= 1'b1;
    end else begin
      if (accept) begin
        tx_valid <= 1'b0;
        thre     <= 1'b1;
        temt     <= 1'b1;
      end
      if (load) begin
        tx_data  <= load_data;
        tx_valid <= 1'b1;
        thre     <= 1'b0;
        temt     <= 1'b0;
      end
    end
  end

  a_r7_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> tx_valid && !thre && !temt);
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !load) |=> tx_valid && $stable(tx_data));
  a_r7_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !load) |=> !tx_valid && thre && temt);

endmodule

// File: rtl/uart16_rx_side.sv
module uart16_rx_side #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  input  logic          drain,
  output logic          rx_ready,
  output logic [DW-1:0] rbr,
  output logic          rx_full,
  output logic          take
);

  assign rx_ready = !rx_full;
  assign take     = rx_valid && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr     <= '0;
      rx_full <= 1'b0;
    end else if (take) begin
      rbr     <= rx_data;
      rx_full <= 1'b1;
    end else if (drain) begin
      rx_full <= 1'b0;
    end
  end

  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rx_full && (rbr == $past(rx_data)));
  a_r8_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !drain) |=> rx_full && $stable(rbr));

endmodule

// File: rtl/uart16_irq_ctrl.sv
module uart16_irq_ctrl
  import uart16_pkg::*;
#(
  parameter int DW = 8,
  parameter int EW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_full,
  input  logic [EW-1:0] ien,
  input  logic          thre,
  input  logic          iid_rd,
  input  logic          ien_wr,
  input  logic          thr_wr,
  input  logic          tx_accept,
  output logic [DW-1:0] iid,
  output logic          irq
);

  logic pend_q, pend_d;
  logic pend_clr;

  assign iid      = iid_code(rx_full, ien[0], pend_q, ien[1]);
  assign irq      = (iid != IID_NONE);
  assign pend_clr = iid_rd && (iid[2:0] == IID_TXE[2:0]);

  always_comb begin
    pend_d = pend_q;
    if (pend_clr)       pend_d = 1'b0;
    if (ien_wr && thre) pend_d = 1'b1;
    if (tx_accept)      pend_d = 1'b1;
    if (thr_wr)         pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !ien_wr && !tx_accept) |=> !pend_q && (iid != IID_TXE));
  a_r6_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_wr && thre && !thr_wr) |=> pend_q);
  a_r4_rx_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && ien[0]) |-> irq && (iid == IID_RXD));

endmodule

// File: rtl/uart16_regs_top.sv
module uart16_regs_top
  import uart16_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   host_addr,
  input  logic [DW-1:0]   host_wdata,
  input  logic            host_wr,
  input  logic            host_rd,
  output logic [DW-1:0]   host_rdata,
  output logic            irq,
  output logic [DW-1:0]   tx_data,
  output logic            tx_valid,
  input  logic            tx_ready,
  input  logic [DW-1:0]   rx_data,
  input  logic            rx_valid,
  output logic            rx_ready,
  output logic [2*DW-1:0] cfg_divisor,
  output logic [3:0]      cfg_word_bits,
  output logic            cfg_stop2,
  output logic            cfg_par_en,
  output logic            cfg_par_even,
  output logic            cfg_break,
  output logic [4:0]      modem_ctl
);

  localparam int DIVW = 2 * DW;

  logic [IEN_BITS-1:0]  ien_q;
  logic [DW-1:0]        lctl_q, scr_q;
  logic [MCTL_BITS-1:0] mctl_q;
  logic [DIVW-1:0]      div_q;

  logic dlab;
  logic [2:0] ofs;
  logic wr_thr, wr_dll, wr_dlm, wr_ien, wr_lctl, wr_mctl, wr_scr;
  logic rd_rbr, rd_iid;

  logic          thre, temt, tx_accept;
  logic [DW-1:0] rbr;
  logic          rx_full, rx_take;
  logic [DW-1:0] iid;

  assign dlab = lctl_q[7];
  assign ofs  = host_addr[2:0];

  assign wr_thr  = host_wr && (ofs == OFS_DATA) && !dlab;
  assign wr_dll  = host_wr && (ofs == OFS_DATA) &&  dlab;
  assign wr_ien  = host_wr && (ofs == OFS_IEN)  && !dlab;
  assign wr_dlm  = host_wr && (ofs == OFS_IEN)  &&  dlab;
  assign wr_lctl = host_wr && (ofs == OFS_LCTL);
  assign wr_mctl = host_wr && (ofs == OFS_MCTL);
  assign wr_scr  = host_wr && (ofs == OFS_SCR);
  assign rd_rbr  = host_rd && (ofs == OFS_DATA) && !dlab;
  assign rd_iid  = host_rd && (ofs == OFS_IID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      lctl_q <= '0;
      mctl_q <= '0;
      scr_q  <= '0;
      div_q  <= '0;
    end else begin
      if (wr_ien)  ien_q  <= host_wdata[IEN_BITS-1:0];
      if (wr_lctl) lctl_q <= host_wdata;
      if (wr_mctl) mctl_q <= host_wdata[MCTL_BITS-1:0];
      if (wr_scr)  scr_q  <= host_wdata;
      if (wr_dll)  div_q[DW-1:0]    <= host_wdata;
      if (wr_dlm)  div_q[DIVW-1:DW] <= host_wdata;
    end
  end

  uart16_tx_side #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(wr_thr), .load_data(host_wdata),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .thre(thre), .temt(temt), .accept(tx_accept)
  );

  uart16_rx_side #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .drain(rd_rbr), .rx_ready(rx_ready), .rbr(rbr), .rx_full(rx_full),
    .take(rx_take)
  );

  uart16_irq_ctrl #(.DW(DW), .EW(IEN_BITS)) u_irq (
    .clk(clk), .rst_n(rst_n), .rx_full(rx_full), .ien(ien_q), .thre(thre),
    .iid_rd(rd_iid), .ien_wr(wr_ien), .thr_wr(wr_thr), .tx_accept(tx_accept),
    .iid(iid), .irq(irq)
  );

  always_comb begin
    unique case (ofs)
      OFS_DATA:  host_rdata = dlab ? div_q[DW-1:0] : rbr;
      OFS_IEN:   host_rdata = dlab ? div_q[DIVW-1:DW] : DW'(ien_q);
      OFS_IID:   host_rdata = iid;
      OFS_LCTL:  host_rdata = lctl_q;
      OFS_MCTL:  host_rdata = DW'(mctl_q);
      OFS_LSTAT: host_rdata = line_status(temt, thre, rx_full);
      OFS_MSTAT: host_rdata = mctl_q[4] ? loop_status(mctl_q) : MSTAT_IDLE;
      default:   host_rdata = scr_q;
    endcase
  end

  assign cfg_divisor   = div_q;
  assign cfg_word_bits = word_bits(lctl_q[1:0]);
  assign cfg_stop2     = lctl_q[2];
  assign cfg_par_en    = lctl_q[3];
  assign cfg_par_even  = lctl_q[4];
  assign cfg_break     = lctl_q[6];
  assign modem_ctl     = mctl_q;

  a_r2_div_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dll |=> (cfg_divisor[DW-1:0] == $past(host_wdata)) && $stable(rbr));
  a_r3_ien_mask: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ien |=> (ien_q == $past(host_wdata[IEN_BITS-1:0])));
  a_r9_loop_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mctl_q[4] && ofs == OFS_MSTAT) |-> (host_rdata[3:0] == 4'h0) && (host_rdata[7] == mctl_q[3]));
  a_r8_ready_gap: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take |=> !rx_ready);

endmodule

// File: tb/uart16_regs_top_tb.sv
`timescale 1ns/1ps
module uart16_regs_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_rdata;
  logic        irq;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [15:0] cfg_divisor;
  logic [3:0]  cfg_word_bits;
  logic        cfg_stop2, cfg_par_en, cfg_par_even, cfg_break;
  logic [4:0]  modem_ctl;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart16_regs_top dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata), .irq(irq),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .cfg_divisor(cfg_divisor), .cfg_word_bits(cfg_word_bits), .cfg_stop2(cfg_stop2),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even), .cfg_break(cfg_break),
    .modem_ctl(modem_ctl)
  );

  // behavioural reference state
  int m_ien, m_lctl, m_mctl, m_scr, m_div, m_rbr, m_txd;
  bit m_full, m_thre, m_temt, m_pend, m_txv;

  function automatic int m_iid();
    if (m_full && (m_ien & 1)) return 4;
    if (m_pend && (m_ien & 2)) return 2;
    return 1;
  endfunction

  function automatic int m_read(int a);
    bit dl = (m_lctl & 128) != 0;
    int v;
    case (a)
      0: return dl ? (m_div % 256) : m_rbr;
      1: return dl ? (m_div / 256) : m_ien;
      2: return m_iid();
      3: return m_lctl;
      4: return m_mctl;
      5: return (m_temt ? 64 : 0) + (m_thre ? 32 : 0) + (m_full ? 1 : 0);
      6: begin
        if ((m_mctl & 16) == 0) return 176;
        v = 0;
        if (m_mctl & 8) v += 128;
        if (m_mctl & 4) v += 64;
        if (m_mctl & 1) v += 32;
        if (m_mctl & 2) v += 16;
        return v;
      end
      default: return m_scr;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ien = 0; m_lctl = 0; m_mctl = 0; m_scr = 0; m_div = 0; m_rbr = 0; m_txd = 0;
      m_full = 0; m_thre = 1; m_temt = 1; m_pend = 0; m_txv = 0;
    end else begin
      int a;
      bit dl, old_thre, acc, take, drain;
      a = int'(host_addr);
      dl = (m_lctl & 128) != 0;
      old_thre = m_thre;
      acc = m_txv && tx_ready;
      take = rx_valid && !m_full;
      drain = host_rd && a == 0 && !dl;
      if (host_rd && a == 2 && m_iid() == 2) m_pend = 0;
      if (acc) begin m_txv = 0; m_thre = 1; m_temt = 1; m_pend = 1; end
      if (host_wr) begin
        case (a)
          0: if (dl) m_div = (m_div / 256) * 256 + int'(host_wdata);
             else begin m_txd = int'(host_wdata); m_txv = 1; m_thre = 0; m_temt = 0; m_pend = 0; end
          1: if (dl) m_div = (m_div % 256) + 256 * int'(host_wdata);
             else begin m_ien = int'(host_wdata) % 16; if (old_thre) m_pend = 1; end
          3: m_lctl = int'(host_wdata);
          4: m_mctl = int'(host_wdata) % 32;
          7: m_scr = int'(host_wdata);
          default: ;
        endcase
      end
      if (take) begin m_rbr = int'(rx_data); m_full = 1; end
      else if (drain) m_full = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 irq", int'(irq), (m_iid() != 1) ? 1 : 0);
      chk("R7 tx_valid", int'(tx_valid), int'(m_txv));
      if (m_txv) chk("R7 tx_data", int'(tx_data), m_txd);
      chk("R8 rx_ready", int'(rx_ready), m_full ? 0 : 1);
      chk("R2 cfg_divisor", int'(cfg_divisor), m_div);
      chk("R11 word_bits", int'(cfg_word_bits), (m_lctl % 4) + 5);
      chk("R11 flags", {cfg_break, cfg_par_even, cfg_par_en, cfg_stop2},
          ((m_lctl / 64) % 2) * 8 + ((m_lctl / 16) % 2) * 4 + ((m_lctl / 8) % 2) * 2 + (m_lctl / 4) % 2);
      chk("R3 modem_ctl", int'(modem_ctl), m_mctl);
      chk("R1 rdata", int'(host_rdata), m_read(int'(host_addr)));
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    host_addr = 3'(a); host_wdata = 8'(d); host_wr = 1'b1;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(posedge clk); #1;
    host_addr = 3'(a); host_rd = 1'b1;
    @(negedge clk);
    chk(tag, int'(host_rdata), exp);
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  task automatic at_negedge(input string tag, input int act_sel, input int exp);
    @(negedge clk);
    case (act_sel)
      0: chk(tag, int'(irq), exp);
      1: chk(tag, int'(tx_valid), exp);
      2: chk(tag, int'(rx_ready), exp);
      3: chk(tag, int'(cfg_divisor), exp);
      default: chk(tag, int'(tx_data), exp);
    endcase
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10 reset values
    rd(5, 8'h60, "R10 line status");
    rd(2, 8'h01, "R10 iid");
    rd(6, 8'hB0, "R10 modem status");
    rd(3, 0, "R10 line control");
    rd(1, 0, "R10 ien");
    at_negedge("R10 irq low", 0, 0);
    at_negedge("R10 tx_valid low", 1, 0);

    // R1 map, ignored writes
    wr(7, 8'hA5); rd(7, 8'hA5, "R1 scratch");
    wr(2, 8'hFF); rd(2, 8'h01, "R1 iid write ignored");
    wr(5, 8'h00); rd(5, 8'h60, "R1 lstat write ignored");
    wr(6, 8'h00); rd(6, 8'hB0, "R1 mstat write ignored");

    // R3 masking; R6 arming
    wr(1, 8'hFF); rd(1, 8'h0F, "R3 ien mask");
    at_negedge("R6 armed irq", 0, 1);
    // R5 offset without strobe
    @(posedge clk); #1 host_addr = 3'd2;
    repeat (4) @(posedge clk);
    at_negedge("R5 no strobe no effect", 0, 1);
    rd(2, 8'h02, "R5 iid txe");
    rd(2, 8'h01, "R5 after clear");
    at_negedge("R5 irq cleared", 0, 0);
    wr(1, 8'h02);
    at_negedge("R6 rearm irq", 0, 1);
    rd(2, 8'h02, "R6 iid txe again");

    // R3 / R9 modem control and loopback
    wr(4, 8'hFF); rd(4, 8'h1F, "R3 mctl mask");
    rd(6, 8'hF0, "R9 loop all");
    wr(4, 8'h15); rd(6, 8'h60, "R9 loop out1 dtr");
    wr(4, 8'h1A); rd(6, 8'h90, "R9 loop out2 rts");
    wr(4, 8'h0F); rd(6, 8'hB0, "R9 no loop");
    wr(4, 8'h00);

    // R11 format decode
    wr(3, 8'h1F); rd(3, 8'h1F, "R11 lctl readback");
    @(negedge clk); chk("R11 word8", int'(cfg_word_bits), 8);
    chk("R11 stop par even", {cfg_stop2, cfg_par_en, cfg_par_even, cfg_break}, 4'b1110);
    wr(3, 8'h40);
    @(negedge clk); chk("R11 word5", int'(cfg_word_bits), 5);
    chk("R11 break", {cfg_stop2, cfg_par_en, cfg_par_even, cfg_break}, 4'b0001);

    // R2 divisor access
    wr(3, 8'h83); wr(0, 8'h34); wr(1, 8'h12);
    at_negedge("R2 divisor out", 3, 16'h1234);
    rd(0, 8'h34, "R2 div low");
    rd(1, 8'h12, "R2 div high");
    at_negedge("R2 no tx on div write", 1, 0);
    wr(3, 8'h03);
    rd(1, 8'h02, "R2 ien untouched");

    // R7 transmit path, stalled downstream
    tx_ready = 1'b0;
    wr(0, 8'h5A);
    at_negedge("R7 tx_valid", 1, 1);
    at_negedge("R7 tx_data", 4, 8'h5A);
    rd(5, 8'h00, "R7 both empty bits low");
    at_negedge("R7 pending cleared", 0, 0);
    repeat (3) @(posedge clk);
    at_negedge("R7 held data", 4, 8'h5A);
    @(posedge clk); #1 tx_ready = 1'b1;
    @(posedge clk); #1 tx_ready = 1'b0;
    at_negedge("R7 accepted", 1, 0);
    rd(5, 8'h60, "R7 empty bits set");
    at_negedge("R7 pending after accept", 0, 1);

    // R4 / R8 receive path and priority
    wr(1, 8'h03);
    @(posedge clk); #1 rx_valid = 1'b1; rx_data = 8'h3C;
    @(posedge clk); #1 rx_valid = 1'b0;
    at_negedge("R8 ready drops", 2, 0);
    rd(2, 8'h04, "R4 rx over tx priority");
    rd(5, 8'h61, "R8 data ready");
    @(posedge clk); #1 rx_valid = 1'b1; rx_data = 8'h77;
    repeat (3) @(posedge clk);
    at_negedge("R8 held off", 2, 0);
    rd(0, 8'h3C, "R8 first byte kept");
    @(posedge clk); #1 rx_valid = 1'b0;
    rd(0, 8'h77, "R8 second byte");
    rd(2, 8'h02, "R4 tx code after drain");
    rd(2, 8'h01, "R4 none");
    wr(1, 8'h00);
    at_negedge("R4 irq off", 0, 0);

    // transmit while receive byte waits, then data write clears pending
    wr(1, 8'h03);
    @(posedge clk); #1 rx_valid = 1'b1; rx_data = 8'hC3;
    @(posedge clk); #1 rx_valid = 1'b0;
    wr(0, 8'h11);
    rd(2, 8'h04, "R4 rx while tx busy");
    rd(0, 8'hC3, "R8 drain");
    rd(2, 8'h01, "R7 write cleared pending");
    tx_ready = 1'b1;
    repeat (2) @(posedge clk);
    rd(2, 8'h02, "R7 accept re-arms");
    tx_ready = 1'b0;

    repeat (2) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule